// File: doc/BRIEF.md
# Receive Giant Packet and Watchdog Checker

This block sits in a receive datapath and watches a byte-wide frame stream. Each frame is marked with start and end strobes, and a tag flag says whether it carries a VLAN tag. The block counts every byte of the frame. It forwards the frame one cycle later and, when a frame runs past the watchdog cut-off, closes the forwarded copy early and drops the excess bytes. When the input frame ends, it reports whether the frame was giant and whether it was truncated.

The giant limit is picked by a fixed precedence. The jumbo setting wins over the 2K setting. The 2K setting wins over the programmable limit. The standard limit applies when none of them is set. The watchdog cut-off is independent of the giant limit. It follows the jumbo setting unless the watchdog is disabled, in which case only the saturating length counter bounds the frame.

Top module: `rx_giant_wd_chk`

## Requirements
- R1: While reset is asserted and right after it, out_valid_o, out_sop_o, out_eop_o, stat_valid_o, stat_giant_o and stat_trunc_o are all 0.
- R2: Each accepted input byte appears on the output one cycle later with the same data and start/end strobes. A frame no longer than the cut-off passes unchanged and is not truncated.
- R3: With jumbo, 2K and programmable limit all clear, a frame is giant when its length exceeds 1518 bytes. If in_tagged_i is high on the end beat, the limit is 1522 bytes.
- R4: With the 2K enable set and jumbo clear, a frame is giant above 2000 bytes, whether it is tagged or not. The programmable limit is ignored.
- R5: With jumbo set, a frame is giant above 9018 bytes, or above 9022 bytes when tagged. The 2K enable has no effect.
- R6: With the programmable-limit enable set and jumbo and 2K clear, a frame is giant above cfg_glim_i when cfg_glim_i exceeds 1518, and above 1518 otherwise. The tag adds nothing in this mode.
- R7: With the watchdog enabled, the cut-off is 2048 bytes, or 10240 bytes with jumbo. For a longer frame, the byte at the cut-off is forwarded with out_eop_o forced high, later bytes are dropped, and stat_trunc_o is 1. A frame exactly at the cut-off is not truncated.
- R8: With the watchdog disabled, frames up to 16383 bytes pass whole. The length counter saturates at 16383, so a longer frame is cut at byte 16383 and flagged truncated.
- R9: stat_valid_o pulses for one cycle, one cycle after the input end beat. stat_giant_o reflects the full received length, even when the frame was truncated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_sop_i | input | 1 | First byte of frame |
| in_eop_i | input | 1 | Last byte of frame |
| in_data_i | input | 8 | Input byte |
| in_tagged_i | input | 1 | Frame is VLAN tagged, sampled on the end beat |
| cfg_jumbo_i | input | 1 | Jumbo frame enable |
| cfg_2k_i | input | 1 | 2000-byte frame enable |
| cfg_glim_en_i | input | 1 | Use the programmable giant limit |
| cfg_glim_i | input | 14 | Programmable giant limit in bytes |
| cfg_wd_dis_i | input | 1 | Disable the watchdog cut-off |
| out_valid_o | output | 1 | Forwarded byte valid |
| out_sop_o | output | 1 | Forwarded first byte |
| out_eop_o | output | 1 | Forwarded last byte, forced at the cut-off |
| out_data_o | output | 8 | Forwarded byte |
| stat_valid_o | output | 1 | End-of-frame status strobe |
| stat_giant_o | output | 1 | Frame exceeded the giant limit |
| stat_trunc_o | output | 1 | Frame was cut by the watchdog or the counter limit |

## Verification
The assertions assume well-formed input frames: a start beat opens every frame, exactly one end beat closes it, and no new start arrives inside a frame. They also assume the configuration inputs hold steady from the first to the last byte of a frame. The stimulus sends complete frames with idle gaps between them and changes configuration only while the stream is idle. Each frame length sits just at or just past the limit under test.

// File: rtl/rx_gw_pkg.sv
package rx_gw_pkg;
  localparam int LEN_W       = 14;
  localparam int DATA_W      = 8;
  localparam int GIANT_STD   = 1518;
  localparam int TAG_EXTRA   = 4;
  localparam int GIANT_2K    = 2000;
  localparam int GIANT_JUMBO = 9018;
  localparam int WD_STD      = 2048;
  localparam int WD_JUMBO    = 10240;
endpackage

// File: rtl/rx_gw_len_cnt.sv
module rx_gw_len_cnt #(
  parameter int LEN_W = rx_gw_pkg::LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             sop_i,
  output logic [LEN_W-1:0] len_o
);
  localparam logic [LEN_W-1:0] LEN_MAX = '1;
  localparam logic [LEN_W-1:0] LEN_ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [LEN_W-1:0] cnt_q;

  // length including the current beat, saturating
  always_comb begin
    if (sop_i)                len_o = LEN_ONE;
    else if (cnt_q == LEN_MAX) len_o = LEN_MAX;
    else                      len_o = cnt_q + LEN_ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (beat_i) cnt_q <= len_o;
  end

  // R8: counter holds at its ceiling instead of wrapping
  a_r8_len_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && !sop_i && cnt_q == LEN_MAX) |=> (cnt_q == LEN_MAX));
endmodule

// File: rtl/rx_gw_limits.sv
module rx_gw_limits #(
  parameter int LEN_W = rx_gw_pkg::LEN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             jumbo_i,
  input  logic             k2_i,
  input  logic             glim_en_i,
  input  logic [LEN_W-1:0] glim_i,
  input  logic             wd_dis_i,
  input  logic             tagged_i,
  output logic [LEN_W-1:0] giant_thr_o,
  output logic [LEN_W-1:0] wd_lim_o
);
  localparam logic [LEN_W-1:0] THR_STD   = LEN_W'(rx_gw_pkg::GIANT_STD);
  localparam logic [LEN_W-1:0] THR_TAG   = LEN_W'(rx_gw_pkg::GIANT_STD + rx_gw_pkg::TAG_EXTRA);
  localparam logic [LEN_W-1:0] THR_2K    = LEN_W'(rx_gw_pkg::GIANT_2K);
  localparam logic [LEN_W-1:0] THR_JMB   = LEN_W'(rx_gw_pkg::GIANT_JUMBO);
  localparam logic [LEN_W-1:0] THR_JMB_T = LEN_W'(rx_gw_pkg::GIANT_JUMBO + rx_gw_pkg::TAG_EXTRA);
  localparam logic [LEN_W-1:0] WD_STD    = LEN_W'(rx_gw_pkg::WD_STD);
  localparam logic [LEN_W-1:0] WD_JMB    = LEN_W'(rx_gw_pkg::WD_JUMBO);
  localparam logic [LEN_W-1:0] LEN_MAX   = '1;

  // precedence: jumbo > 2K > programmable > standard
  always_comb begin
    if (jumbo_i)        giant_thr_o = tagged_i ? THR_JMB_T : THR_JMB;
    else if (k2_i)      giant_thr_o = THR_2K;
    else if (glim_en_i) giant_thr_o = (glim_i > THR_STD) ? glim_i : THR_STD;
    else                giant_thr_o = tagged_i ? THR_TAG : THR_STD;
  end

  always_comb begin
    if (wd_dis_i)     wd_lim_o = LEN_MAX;
    else if (jumbo_i) wd_lim_o = WD_JMB;
    else              wd_lim_o = WD_STD;
  end

  // R6: programmable limit never drops below the standard floor
  a_r6_glim_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glim_en_i |-> (giant_thr_o >= THR_STD));
  // R5: jumbo overrides every lower-priority setting
  a_r5_jumbo_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jumbo_i |-> (giant_thr_o >= THR_JMB));
endmodule

// File: rtl/rx_gw_cut.sv
module rx_gw_cut #(
  parameter int DATA_W = rx_gw_pkg::DATA_W,
  parameter int LEN_W  = rx_gw_pkg::LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LEN_W-1:0]  giant_thr_i,
  input  logic [LEN_W-1:0]  wd_lim_i,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              stat_valid_o,
  output logic              stat_giant_o,
  output logic              stat_trunc_o
);
  logic cut_q, cut_active, at_lim, fwd, cut_new, last_beat;

  assign cut_active = in_sop_i ? 1'b0 : cut_q;
  assign at_lim     = (len_i == wd_lim_i);
  assign fwd        = !cut_active && (len_i <= wd_lim_i);
  assign cut_new    = fwd && at_lim && !in_eop_i;
  assign last_beat  = in_valid_i && in_eop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cut_q <= 1'b0;
    else if (in_valid_i) cut_q <= in_eop_i ? 1'b0 : (cut_active | cut_new);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_sop_o    <= 1'b0;
      out_eop_o    <= 1'b0;
      out_data_o   <= '0;
      stat_valid_o <= 1'b0;
      stat_giant_o <= 1'b0;
      stat_trunc_o <= 1'b0;
    end else begin
      out_valid_o  <= in_valid_i && fwd;
      out_sop_o    <= in_valid_i && fwd && in_sop_i;
      out_eop_o    <= in_valid_i && fwd && (in_eop_i || at_lim);
      if (in_valid_i && fwd) out_data_o <= in_data_i;
      stat_valid_o <= last_beat;
      stat_giant_o <= last_beat && (len_i > giant_thr_i);
      stat_trunc_o <= last_beat && cut_active;
    end
  end

  // checker: forwarded bytes in the current output frame
  logic [LEN_W:0] chk_len_q, chk_len_now;
  assign chk_len_now = out_sop_o ? (LEN_W+1)'(1) : chk_len_q + (LEN_W+1)'(1);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          chk_len_q <= '0;
    else if (out_valid_o) chk_len_q <= chk_len_now;
  end

  // R7: forwarded frame never longer than the cut-off
  a_r7_out_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (chk_len_now <= {1'b0, wd_lim_i}));
  // R7: a truncated frame's trailing input beat is not forwarded
  a_r7_trunc_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && stat_trunc_o) |-> !out_valid_o);
  // R2: an untruncated frame ends on the output with its status
  a_r2_plain_eop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_valid_o && !stat_trunc_o) |-> (out_valid_o && out_eop_o));
  // R9: status follows an input end beat
  a_r9_stat_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_valid_o |-> $past(in_valid_i && in_eop_i));
endmodule

// File: rtl/rx_giant_wd_chk.sv
module rx_giant_wd_chk #(
  parameter int DATA_W = rx_gw_pkg::DATA_W,
  parameter int LEN_W  = rx_gw_pkg::LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_tagged_i,
  input  logic              cfg_jumbo_i,
  input  logic              cfg_2k_i,
  input  logic              cfg_glim_en_i,
  input  logic [LEN_W-1:0]  cfg_glim_i,
  input  logic              cfg_wd_dis_i,
  output logic              out_valid_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              stat_valid_o,
  output logic              stat_giant_o,
  output logic              stat_trunc_o
);
  logic [LEN_W-1:0] len_cur, giant_thr, wd_lim;

  rx_gw_len_cnt #(.LEN_W(LEN_W)) u_len (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .beat_i (in_valid_i),
    .sop_i  (in_sop_i),
    .len_o  (len_cur)
  );

  rx_gw_limits #(.LEN_W(LEN_W)) u_lim (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .jumbo_i     (cfg_jumbo_i),
    .k2_i        (cfg_2k_i),
    .glim_en_i   (cfg_glim_en_i),
    .glim_i      (cfg_glim_i),
    .wd_dis_i    (cfg_wd_dis_i),
    .tagged_i    (in_tagged_i),
    .giant_thr_o (giant_thr),
    .wd_lim_o    (wd_lim)
  );

  rx_gw_cut #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_cut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid_i),
    .in_sop_i     (in_sop_i),
    .in_eop_i     (in_eop_i),
    .in_data_i    (in_data_i),
    .len_i        (len_cur),
    .giant_thr_i  (giant_thr),
    .wd_lim_i     (wd_lim),
    .out_valid_o  (out_valid_o),
    .out_sop_o    (out_sop_o),
    .out_eop_o    (out_eop_o),
    .out_data_o   (out_data_o),
    .stat_valid_o (stat_valid_o),
    .stat_giant_o (stat_giant_o),
    .stat_trunc_o (stat_trunc_o)
  );
endmodule

// File: tb/rx_giant_wd_chk_tb.sv
`timescale 1ns/1ps
module rx_giant_wd_chk_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_tagged = 0;
  logic [7:0] in_data = '0;
  logic cfg_jumbo = 0, cfg_2k = 0, cfg_glim_en = 0, cfg_wd_dis = 0;
  logic [13:0] cfg_glim = '0;
  logic out_valid, out_sop, out_eop, stat_valid, stat_giant, stat_trunc;
  logic [7:0] out_data;

  int tests = 0, fails = 0, beat_err = 0;

  typedef struct packed { logic [7:0] d; logic s; logic e; } beat_t;
  typedef struct packed { logic g; logic t; } stat_t;
  beat_t beat_q[$];
  stat_t st_q[$];
  string req_q[$];

  always #4 clk = ~clk;

  rx_giant_wd_chk u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .in_data_i(in_data), .in_tagged_i(in_tagged),
    .cfg_jumbo_i(cfg_jumbo), .cfg_2k_i(cfg_2k), .cfg_glim_en_i(cfg_glim_en),
    .cfg_glim_i(cfg_glim), .cfg_wd_dis_i(cfg_wd_dis),
    .out_valid_o(out_valid), .out_sop_o(out_sop), .out_eop_o(out_eop),
    .out_data_o(out_data), .stat_valid_o(stat_valid),
    .stat_giant_o(stat_giant), .stat_trunc_o(stat_trunc)
  );

  function automatic int exp_thr(input bit tag);
    if (cfg_jumbo)        return tag ? 9022 : 9018;
    else if (cfg_2k)      return 2000;
    else if (cfg_glim_en) return (int'(cfg_glim) > 1518) ? int'(cfg_glim) : 1518;
    else                  return tag ? 1522 : 1518;
  endfunction

  function automatic int exp_lim();
    if (cfg_wd_dis)     return 16383;
    else if (cfg_jumbo) return 10240;
    else                return 2048;
  endfunction

  task automatic set_cfg(input bit j, input bit k, input bit ge, input int gl, input bit wdd);
    cfg_jumbo = j; cfg_2k = k; cfg_glim_en = ge; cfg_glim = 14'(gl); cfg_wd_dis = wdd;
  endtask

  // driver: queue expectations, then drive the frame
  task automatic send_frame(input int len, input bit tag, input string req);
    int lim, thr, nf;
    lim = exp_lim();
    thr = exp_thr(tag);
    nf  = (len < lim) ? len : lim;
    for (int i = 0; i < nf; i++)
      beat_q.push_back('{d: 8'(i*3 + len), s: (i == 0), e: (i == nf-1)});
    st_q.push_back('{g: (len > thr), t: (len > lim)});
    req_q.push_back(req);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      in_valid = 1; in_sop = (i == 0); in_eop = (i == len-1);
      in_data = 8'(i*3 + len); in_tagged = tag;
    end
    @(posedge clk); #1;
    in_valid = 0; in_sop = 0; in_eop = 0; in_tagged = 0;
    repeat (3) @(posedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        if (beat_q.size() == 0) beat_err++;
        else begin
          beat_t b;
          b = beat_q.pop_front();
          if ({out_data, out_sop, out_eop} != b) beat_err++;
        end
      end
      if (stat_valid) begin
        if (st_q.size() == 0) begin
          tests++; fails++;
          $display("FAIL R9 unexpected status actual 1 expected 0");
        end else begin
          stat_t s;
          string r;
          s = st_q.pop_front();
          r = req_q.pop_front();
          tests++;
          if ({stat_giant, stat_trunc} != s) begin
            fails++;
            $display("FAIL %s status giant,trunc actual %b%b expected %b%b",
                     r, stat_giant, stat_trunc, s.g, s.t);
          end
          tests++;
          if (beat_err != 0 || beat_q.size() != 0) begin
            fails++;
            $display("FAIL %s R2 stream mismatches actual %0d/%0d left expected 0/0",
                     r, beat_err, beat_q.size());
          end
          beat_err = 0;
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tests++;
    if ({out_valid, out_sop, out_eop, stat_valid, stat_giant, stat_trunc} != 6'b0) begin
      fails++;
      $display("FAIL R1 reset outputs actual %b expected 000000",
               {out_valid, out_sop, out_eop, stat_valid, stat_giant, stat_trunc});
    end
    #1 rst_n = 1'b1;
    @(negedge clk);
    tests++;
    if ({out_valid, stat_valid} != 2'b0) begin
      fails++;
      $display("FAIL R1 after reset actual %b expected 00", {out_valid, stat_valid});
    end

    set_cfg(0, 0, 0, 0, 0);
    send_frame(64,   0, "R2 short frame");
    send_frame(1518, 0, "R3 std at limit");
    send_frame(1519, 0, "R3 std over");
    send_frame(1522, 1, "R3 tagged at limit");
    send_frame(1523, 1, "R3 tagged over");
    send_frame(2048, 0, "R7 exactly cut-off");
    send_frame(2049, 0, "R7 R9 cut and giant");

    set_cfg(0, 1, 1, 1600, 0);
    send_frame(2000, 1, "R4 2k at limit");
    send_frame(2001, 1, "R4 2k over tagged");

    set_cfg(1, 1, 0, 0, 0);
    send_frame(9018, 0, "R5 jumbo at limit");
    send_frame(9019, 0, "R5 jumbo over");
    send_frame(9022, 1, "R5 jumbo tagged at limit");
    send_frame(10241, 1, "R7 jumbo cut-off");

    set_cfg(0, 0, 1, 1600, 0);
    send_frame(1600, 1, "R6 prog at limit");
    send_frame(1601, 0, "R6 prog over");
    set_cfg(0, 0, 1, 1000, 0);
    send_frame(1518, 0, "R6 floor at limit");
    send_frame(1519, 0, "R6 floor over");

    set_cfg(0, 0, 0, 0, 1);
    send_frame(3000, 0, "R8 wd off no cut");
    send_frame(16384, 0, "R8 saturate cut");

    repeat (5) @(posedge clk);
    tests++;
    if (st_q.size() != 0 || beat_q.size() != 0) begin
      fails++;
      $display("FAIL R9 pending items actual %0d/%0d expected 0/0", st_q.size(), beat_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule